// File: doc/BRIEF.md
# Dual-Port Word RAM with Bus-Side Address Mirroring

This block is a word-organised memory with two independent ports. One port is a Wishbone classic slave that handles single read and write accesses. The other port is a plain synchronous port for the user logic around it. The word count, word width, bus width, byte-lane writes and the per-port access rights are parameters. The user port can run on its own clock or share the bus clock.

Every memory word occupies exactly one bus word address, and words are never packed. A word narrower than the bus is zero-extended on reads. The bus address is wider than the array needs by `WRAP_BITS` bits, and those bits are ignored. The array therefore appears `2**WRAP_BITS` times in a row in the bus address space. A pointer that steps past the last word lands on word 0 with no extra arithmetic, which suits ring buffers.

There is no back-pressure on either side. The bus side paces itself with its acknowledge: one request is taken per strobe, and it is answered one cycle later. The user port accepts a request on every enabled clock edge. Both ports are set by parameters, each to read-only, write-only or read-write. Elaboration stops if both ports are read-only or both are write-only, if `WORDS` is not a power of two, or if the word is wider than the bus.

Top module: `wb_mirror_dpram`

## Requirements
- R1: `WORDS` is a power of two. The word address is taken from the low `log2(WORDS)` bits of `wb_adr`. Each word has its own bus address. In a bus read, data bits at and above `DATA_W` are zero.
- R2: The top `WRAP_BITS` bits of `wb_adr` are ignored, so bus address `k + n*WORDS` reaches the same word as `k` for any `n`.
- R3: `wb_ack` is low out of reset. It goes high for exactly one cycle, in the cycle after the first cycle in which `wb_cyc` and `wb_stb` are both high. Read data is valid while `wb_ack` is high.
- R4: With `BYTE_SEL=1`, a bus write changes only the bytes whose `wb_sel` bit is set, where bit i covers data bits 8i+7..8i. A write with all select bits clear changes nothing. With `BYTE_SEL=0`, a bus write replaces the whole word whatever `wb_sel` holds.
- R5: A user read is requested with `usr_en=1` and `usr_we=0`. `usr_rdata` shows the addressed word after the next user-port clock edge, and keeps its previous value until that edge.
- R6: With `BYTE_SEL=1`, a user write changes only the bytes whose `usr_be` bit is set, using the same bit-to-byte mapping as R4.
- R7: A word written through one port is returned by a read on the other port that starts after the write has completed, including when the two clocks are unrelated.
- R8: A write on a port configured read-only leaves the memory unchanged. On the bus side, such a write is still acknowledged.
- R9: A read on a port configured write-only returns zero.
- R10: With `SEPARATE_CLK=0`, the user port is timed by `wb_clk`, and `usr_clk` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wb_clk | input | 1 | Bus clock |
| wb_rst | input | 1 | Synchronous active-high reset of the bus side |
| wb_cyc | input | 1 | Bus cycle in progress |
| wb_stb | input | 1 | Bus strobe for a single access |
| wb_we | input | 1 | Bus write when high, read when low |
| wb_adr | input | log2(WORDS)+WRAP_BITS | Bus word address; the top WRAP_BITS bits are ignored |
| wb_sel | input | BUS_W/8 | Bus byte-lane selects |
| wb_dat_w | input | BUS_W | Bus write data; the low DATA_W bits are stored |
| wb_dat_r | output | BUS_W | Bus read data, zero-extended |
| wb_ack | output | 1 | One-cycle acknowledge |
| usr_clk | input | 1 | User-port clock, used when SEPARATE_CLK=1 |
| usr_en | input | 1 | User-port request enable |
| usr_we | input | 1 | User-port write when high |
| usr_addr | input | log2(WORDS) | User-port word address |
| usr_be | input | ceil(DATA_W/8) | User-port byte-write enables |
| usr_wdata | input | DATA_W | User-port write data |
| usr_rdata | output | DATA_W | User-port read data, one clock of latency |

## Verification
A bus result is due at the first bus clock edge after the strobe is seen. The bench therefore samples `wb_ack` 1 ns after it drives a request, where it must still be low. It samples `wb_ack` and `wb_dat_r` again at the next falling edge, and once more one cycle later, when the acknowledge must have dropped. A user read is due at the user clock edge after the request. The bench takes the value shortly after driving the request, where the old word must still be present, and again at the next falling edge of that port's clock. Cross-port checks start a read on the other port only after the writing access has finished.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    ACC_RO = 2'd0,
    ACC_WO = 2'd1,
    ACC_RW = 2'd2
  } acc_e;

  function automatic logic acc_can_read(acc_e mode);
    return mode != ACC_WO;
  endfunction

  function automatic logic acc_can_write(acc_e mode);
    return mode != ACC_RO;
  endfunction

endpackage

// File: rtl/dpr_ram.sv
module dpr_ram #(
  parameter int WORDS      = 256,
  parameter int DATA_W     = 32,
  parameter bit SHARED_CLK = 1'b1,
  parameter bit WR_A       = 1'b1,
  parameter bit WR_B       = 1'b1,
  localparam int AW        = $clog2(WORDS),
  localparam int LANES     = (DATA_W + 7) / 8
) (
  input  logic              clk_a,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [LANES-1:0]  a_be,
  input  logic [DATA_W-1:0] a_wd,
  output logic [DATA_W-1:0] a_q,
  input  logic              clk_b,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [AW-1:0]     b_addr,
  input  logic [LANES-1:0]  b_be,
  input  logic [DATA_W-1:0] b_wd,
  output logic [DATA_W-1:0] b_q
);

  // storage is padded to whole bytes so a partial top lane is still addressable
  localparam int MW = LANES * 8;

  logic [MW-1:0] mem [WORDS];
  logic [MW-1:0] a_qw;
  logic [MW-1:0] b_qw;

  assign a_q = a_qw[DATA_W-1:0];
  assign b_q = b_qw[DATA_W-1:0];

  function automatic logic [MW-1:0] merge(input logic [MW-1:0] old,
                                          input logic [DATA_W-1:0] wd,
                                          input logic [LANES-1:0] be);
    logic [MW-1:0] wide;
    logic [MW-1:0] res;
    wide = MW'(wd);
    res  = old;
    for (int l = 0; l < LANES; l++) begin
      if (be[l]) res[l*8 +: 8] = wide[l*8 +: 8];
    end
    return res;
  endfunction

  if (SHARED_CLK) begin : g_shared
    always_ff @(posedge clk_a) begin
      if (a_en && a_we) mem[a_addr] <= merge(mem[a_addr], a_wd, a_be);
      if (b_en && b_we) mem[b_addr] <= merge(mem[b_addr], b_wd, b_be);
      if (a_en) a_qw <= mem[a_addr];
      if (b_en) b_qw <= mem[b_addr];
    end
  end else if (WR_A && WR_B) begin : g_two_writers
    always_ff @(posedge clk_a) begin
      if (a_en && a_we) mem[a_addr] <= merge(mem[a_addr], a_wd, a_be);
      if (a_en) a_qw <= mem[a_addr];
    end
    always_ff @(posedge clk_b) begin
      if (b_en && b_we) mem[b_addr] <= merge(mem[b_addr], b_wd, b_be);
      if (b_en) b_qw <= mem[b_addr];
    end
  end else if (WR_A) begin : g_a_writes
    always_ff @(posedge clk_a) begin
      if (a_en && a_we) mem[a_addr] <= merge(mem[a_addr], a_wd, a_be);
      if (a_en) a_qw <= mem[a_addr];
    end
    always_ff @(posedge clk_b) begin
      if (b_en) b_qw <= mem[b_addr];
    end
  end else begin : g_b_writes
    always_ff @(posedge clk_a) begin
      if (a_en) a_qw <= mem[a_addr];
    end
    always_ff @(posedge clk_b) begin
      if (b_en && b_we) mem[b_addr] <= merge(mem[b_addr], b_wd, b_be);
      if (b_en) b_qw <= mem[b_addr];
    end
  end

  // inputs that a given variant leaves idle
  logic unused_ram;
  assign unused_ram = ^{clk_b, a_we, a_be, a_wd, b_we, b_be, b_wd};

endmodule

// File: rtl/dpr_wb_port.sv
module dpr_wb_port #(
  parameter int AW       = 8,
  parameter int WB_AW    = 9,
  parameter int BUS_W    = 32,
  parameter int DATA_W   = 32,
  parameter bit BYTE_SEL = 1'b1,
  parameter bit CAN_RD   = 1'b1,
  parameter bit CAN_WR   = 1'b1,
  localparam int LANES     = (DATA_W + 7) / 8,
  localparam int BUS_LANES = BUS_W / 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cyc,
  input  logic                 stb,
  input  logic                 we,
  input  logic [WB_AW-1:0]     adr,
  input  logic [BUS_LANES-1:0] sel,
  input  logic [BUS_W-1:0]     dat_w,
  output logic [BUS_W-1:0]     dat_r,
  output logic                 ack,
  output logic                 m_en,
  output logic                 m_we,
  output logic [AW-1:0]        m_addr,
  output logic [LANES-1:0]     m_be,
  output logic [DATA_W-1:0]    m_wd,
  input  logic [DATA_W-1:0]    m_q
);

  logic req;

  // a strobe held across its own acknowledge is not a second request
  assign req = cyc && stb && !ack;

  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b0;
    else     ack <= req;
  end

  assign m_en   = req;
  assign m_we   = req && we && CAN_WR;
  assign m_addr = adr[AW-1:0];          // mirror bits above AW are dropped
  assign m_wd   = dat_w[DATA_W-1:0];

  if (BYTE_SEL) begin : g_lanes
    assign m_be = sel[LANES-1:0];
  end else begin : g_full_word
    assign m_be = '1;
  end

  if (CAN_RD) begin : g_readable
    assign dat_r = ack ? BUS_W'(m_q) : '0;
  end else begin : g_unreadable
    assign dat_r = '0;
  end

  logic unused_wb;
  assign unused_wb = ^{adr, sel, dat_w};

endmodule

// File: rtl/dpr_usr_port.sv
module dpr_usr_port #(
  parameter int DATA_W   = 32,
  parameter bit BYTE_SEL = 1'b1,
  parameter bit CAN_RD   = 1'b1,
  parameter bit CAN_WR   = 1'b1,
  localparam int LANES   = (DATA_W + 7) / 8
) (
  input  logic              en,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] rdata,
  output logic              m_we,
  output logic [LANES-1:0]  m_be,
  input  logic [DATA_W-1:0] m_q
);

  assign m_we = en && we && CAN_WR;

  if (BYTE_SEL) begin : g_lanes
    assign m_be = be;
  end else begin : g_full_word
    assign m_be = '1;
  end

  if (CAN_RD) begin : g_readable
    assign rdata = m_q;
  end else begin : g_unreadable
    assign rdata = '0;
  end

  logic unused_usr;
  assign unused_usr = ^{be, m_q};

endmodule

// File: rtl/wb_mirror_dpram.sv
module wb_mirror_dpram #(
  parameter int             WORDS        = 256,
  parameter int             DATA_W       = 32,
  parameter int             BUS_W        = 32,
  parameter bit             BYTE_SEL     = 1'b1,
  parameter int             WRAP_BITS    = 1,
  parameter bit             SEPARATE_CLK = 1'b0,
  parameter dpr_pkg::acc_e  BUS_MODE     = dpr_pkg::ACC_RW,
  parameter dpr_pkg::acc_e  USER_MODE    = dpr_pkg::ACC_WO,
  localparam int AW        = $clog2(WORDS),
  localparam int WB_AW     = AW + WRAP_BITS,
  localparam int LANES     = (DATA_W + 7) / 8,
  localparam int BUS_LANES = BUS_W / 8
) (
  input  logic                 wb_clk,
  input  logic                 wb_rst,
  input  logic                 wb_cyc,
  input  logic                 wb_stb,
  input  logic                 wb_we,
  input  logic [WB_AW-1:0]     wb_adr,
  input  logic [BUS_LANES-1:0] wb_sel,
  input  logic [BUS_W-1:0]     wb_dat_w,
  output logic [BUS_W-1:0]     wb_dat_r,
  output logic                 wb_ack,
  input  logic                 usr_clk,
  input  logic                 usr_en,
  input  logic                 usr_we,
  input  logic [AW-1:0]        usr_addr,
  input  logic [LANES-1:0]     usr_be,
  input  logic [DATA_W-1:0]    usr_wdata,
  output logic [DATA_W-1:0]    usr_rdata
);

  localparam bit BUS_CAN_RD = dpr_pkg::acc_can_read(BUS_MODE);
  localparam bit BUS_CAN_WR = dpr_pkg::acc_can_write(BUS_MODE);
  localparam bit USR_CAN_RD = dpr_pkg::acc_can_read(USER_MODE);
  localparam bit USR_CAN_WR = dpr_pkg::acc_can_write(USER_MODE);

  if (BUS_MODE == USER_MODE && BUS_MODE != dpr_pkg::ACC_RW) begin : g_bad_modes
    $error("wb_mirror_dpram: both ports read-only or both write-only");
  end
  if (WORDS < 2 || (1 << AW) != WORDS) begin : g_bad_words
    $error("wb_mirror_dpram: WORDS must be a power of two of at least 2");
  end
  if (DATA_W < 1 || DATA_W > BUS_W || (BUS_W % 8) != 0) begin : g_bad_width
    $error("wb_mirror_dpram: DATA_W must be 1..BUS_W and BUS_W whole bytes");
  end

  logic              a_en, a_we;
  logic [AW-1:0]     a_addr;
  logic [LANES-1:0]  a_be;
  logic [DATA_W-1:0] a_wd, a_q;
  logic              b_we;
  logic [LANES-1:0]  b_be;
  logic [DATA_W-1:0] b_q;

  dpr_wb_port #(
    .AW(AW), .WB_AW(WB_AW), .BUS_W(BUS_W), .DATA_W(DATA_W),
    .BYTE_SEL(BYTE_SEL), .CAN_RD(BUS_CAN_RD), .CAN_WR(BUS_CAN_WR)
  ) u_wb (
    .clk(wb_clk), .rst(wb_rst), .cyc(wb_cyc), .stb(wb_stb), .we(wb_we),
    .adr(wb_adr), .sel(wb_sel), .dat_w(wb_dat_w), .dat_r(wb_dat_r), .ack(wb_ack),
    .m_en(a_en), .m_we(a_we), .m_addr(a_addr), .m_be(a_be), .m_wd(a_wd), .m_q(a_q)
  );

  dpr_usr_port #(
    .DATA_W(DATA_W), .BYTE_SEL(BYTE_SEL), .CAN_RD(USR_CAN_RD), .CAN_WR(USR_CAN_WR)
  ) u_usr (
    .en(usr_en), .we(usr_we), .be(usr_be), .rdata(usr_rdata),
    .m_we(b_we), .m_be(b_be), .m_q(b_q)
  );

  dpr_ram #(
    .WORDS(WORDS), .DATA_W(DATA_W), .SHARED_CLK(!SEPARATE_CLK),
    .WR_A(BUS_CAN_WR), .WR_B(USR_CAN_WR)
  ) u_ram (
    .clk_a(wb_clk), .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_be(a_be),
    .a_wd(a_wd), .a_q(a_q),
    .clk_b(usr_clk), .b_en(usr_en), .b_we(b_we), .b_addr(usr_addr), .b_be(b_be),
    .b_wd(usr_wdata), .b_q(b_q)
  );

endmodule

// File: rtl/dpr_checks.sv
module dpr_checks #(
  parameter int DATA_W = 32,
  parameter int BUS_W  = 32,
  parameter bit BUS_RD = 1'b1,
  parameter bit USR_RD = 1'b1
) (
  input logic              wb_clk,
  input logic              wb_rst,
  input logic              wb_cyc,
  input logic              wb_stb,
  input logic              wb_we,
  input logic              wb_ack,
  input logic [BUS_W-1:0]  wb_dat_r,
  input logic [DATA_W-1:0] usr_rdata
);

  // R3: an acknowledge lasts a single cycle
  p_ack_single_r3: assert property (@(posedge wb_clk) disable iff (wb_rst)
    wb_ack |=> !wb_ack);

  // R3: a fresh request is acknowledged in the next cycle
  p_ack_due_r3: assert property (@(posedge wb_clk) disable iff (wb_rst)
    (wb_cyc && wb_stb && !wb_ack) |=> wb_ack);

  // R3: no acknowledge without a strobe in the cycle before
  p_ack_needs_req_r3: assert property (@(posedge wb_clk) disable iff (wb_rst)
    wb_ack |-> $past(wb_cyc && wb_stb));

  // R1: bus data above the word width reads as zero
  p_upper_zero_r1: assert property (@(posedge wb_clk) disable iff (wb_rst)
    (wb_ack && !wb_we) |-> ((wb_dat_r >> DATA_W) == '0));

  // R9: a write-only bus side returns zero
  p_bus_wo_zero_r9: assert property (@(posedge wb_clk) disable iff (wb_rst)
    (!BUS_RD && wb_ack) |-> (wb_dat_r == '0));

  // R9: a write-only user side returns zero
  p_usr_wo_zero_r9: assert property (@(posedge wb_clk) disable iff (wb_rst)
    !USR_RD |-> (usr_rdata == '0));

endmodule

bind wb_mirror_dpram dpr_checks #(
  .DATA_W(DATA_W), .BUS_W(BUS_W), .BUS_RD(BUS_CAN_RD), .USR_RD(USR_CAN_RD)
) u_checks (
  .wb_clk(wb_clk), .wb_rst(wb_rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
  .wb_we(wb_we), .wb_ack(wb_ack), .wb_dat_r(wb_dat_r), .usr_rdata(usr_rdata)
);

// File: tb/test_wb_mirror_dpram.sv
module test_wb_mirror_dpram;
  timeunit 1ns;
  timeprecision 1ps;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic wb_clk = 0;
  logic uclk   = 0;
  logic wb_rst = 1;
  always #4 wb_clk = ~wb_clk;      // 125 MHz
  always #5.5 uclk = ~uclk;        // unrelated user clock for the second instance

  // main instance: 256 x 32, byte lanes, 1 mirror bit, shared clock, bus RW, user WO
  logic        m_cyc = 0, m_stb = 0, m_we = 0;
  logic [8:0]  m_adr = '0;
  logic [3:0]  m_sel = '0;
  logic [31:0] m_wdat = '0, m_rdat;
  logic        m_ack;
  logic        m_uen = 0, m_uwe = 0;
  logic [7:0]  m_uaddr = '0;
  logic [3:0]  m_ube = '0;
  logic [31:0] m_uwd = '0, m_urd;

  wb_mirror_dpram i_wb_mirror_dpram (
    .wb_clk(wb_clk), .wb_rst(wb_rst), .wb_cyc(m_cyc), .wb_stb(m_stb), .wb_we(m_we),
    .wb_adr(m_adr), .wb_sel(m_sel), .wb_dat_w(m_wdat), .wb_dat_r(m_rdat), .wb_ack(m_ack),
    .usr_clk(1'b0), .usr_en(m_uen), .usr_we(m_uwe), .usr_addr(m_uaddr), .usr_be(m_ube),
    .usr_wdata(m_uwd), .usr_rdata(m_urd)
  );

  // second instance: 64 x 16, no byte lanes, 2 mirror bits, own clock, bus RW, user RO
  logic        a_cyc = 0, a_stb = 0, a_we = 0;
  logic [7:0]  a_adr = '0;
  logic [3:0]  a_sel = '0;
  logic [31:0] a_wdat = '0, a_rdat;
  logic        a_ack;
  logic        a_uen = 0, a_uwe = 0;
  logic [5:0]  a_uaddr = '0;
  logic [15:0] a_uwd = '0, a_urd;

  wb_mirror_dpram #(
    .WORDS(64), .DATA_W(16), .BUS_W(32), .BYTE_SEL(1'b0), .WRAP_BITS(2),
    .SEPARATE_CLK(1'b1), .BUS_MODE(dpr_pkg::ACC_RW), .USER_MODE(dpr_pkg::ACC_RO)
  ) i_wb_mirror_dpram_alt (
    .wb_clk(wb_clk), .wb_rst(wb_rst), .wb_cyc(a_cyc), .wb_stb(a_stb), .wb_we(a_we),
    .wb_adr(a_adr), .wb_sel(a_sel), .wb_dat_w(a_wdat), .wb_dat_r(a_rdat), .wb_ack(a_ack),
    .usr_clk(uclk), .usr_en(a_uen), .usr_we(a_uwe), .usr_addr(a_uaddr), .usr_be(2'b11),
    .usr_wdata(a_uwd), .usr_rdata(a_urd)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one bus access; R3 timing of the acknowledge is checked on every call
  task automatic wb_access(input bit alt, input bit we, input logic [31:0] adr,
                           input logic [3:0] sel, input logic [31:0] wd,
                           output logic [31:0] rd);
    @(negedge wb_clk);
    if (!alt) begin
      m_cyc = 1; m_stb = 1; m_we = we; m_adr = adr[8:0]; m_sel = sel; m_wdat = wd;
    end else begin
      a_cyc = 1; a_stb = 1; a_we = we; a_adr = adr[7:0]; a_sel = sel; a_wdat = wd;
    end
    #1 check("R3", "ack low before edge", {31'd0, alt ? a_ack : m_ack}, 32'd0);
    @(negedge wb_clk);
    check("R3", "ack one cycle after strobe", {31'd0, alt ? a_ack : m_ack}, 32'd1);
    rd = alt ? a_rdat : m_rdat;
    m_cyc = 0; m_stb = 0; m_we = 0; a_cyc = 0; a_stb = 0; a_we = 0;
    @(negedge wb_clk);
    check("R3", "ack dropped after one cycle", {31'd0, alt ? a_ack : m_ack}, 32'd0);
  endtask

  task automatic usr_main(input bit we, input logic [7:0] addr, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd);
    @(negedge wb_clk);
    m_uen = 1; m_uwe = we; m_uaddr = addr; m_ube = be; m_uwd = wd;
    @(negedge wb_clk);
    rd = m_urd;
    m_uen = 0; m_uwe = 0;
  endtask

  task automatic usr_alt(input bit we, input logic [5:0] addr, input logic [15:0] wd,
                         output logic [15:0] pre, output logic [15:0] rd);
    @(negedge uclk);
    a_uen = 1; a_uwe = we; a_uaddr = addr; a_uwd = wd;
    #1 pre = a_urd;
    @(negedge uclk);
    rd = a_urd;
    a_uen = 0; a_uwe = 0;
  endtask

  task automatic t_reset;
    check("R3", "main ack after reset", {31'd0, m_ack}, 32'd0);
    check("R3", "alt ack after reset", {31'd0, a_ack}, 32'd0);
  endtask

  task automatic t_basic;
    logic [31:0] rd;
    wb_access(0, 1, 0,   4'hF, 32'hDEADBEEF, rd);
    wb_access(0, 1, 1,   4'hF, 32'h01234567, rd);
    wb_access(0, 1, 255, 4'hF, 32'hA5A55A5A, rd);
    wb_access(0, 0, 0,   4'hF, 0, rd); check("R1", "word 0", rd, 32'hDEADBEEF);
    wb_access(0, 0, 1,   4'hF, 0, rd); check("R1", "word 1", rd, 32'h01234567);
    wb_access(0, 0, 255, 4'hF, 0, rd); check("R1", "last word", rd, 32'hA5A55A5A);
  endtask

  task automatic t_mirror;
    logic [31:0] rd;
    wb_access(0, 1, 256 + 7, 4'hF, 32'h77770007, rd);
    wb_access(0, 0, 7, 4'hF, 0, rd);       check("R2", "mirror write seen at base", rd, 32'h77770007);
    wb_access(0, 1, 3, 4'hF, 32'h00003333, rd);
    wb_access(0, 0, 256 + 3, 4'hF, 0, rd); check("R2", "base write seen in mirror", rd, 32'h00003333);
    wb_access(0, 0, 256, 4'hF, 0, rd);     check("R2", "past last word wraps to 0", rd, 32'hDEADBEEF);
  endtask

  task automatic t_bus_lanes;
    logic [31:0] rd;
    wb_access(0, 1, 20, 4'hF, 32'hFFFFFFFF, rd);
    wb_access(0, 1, 20, 4'b0101, 32'h11223344, rd);
    wb_access(0, 0, 20, 4'hF, 0, rd); check("R4", "lanes 0 and 2", rd, 32'hFF22FF44);
    wb_access(0, 1, 20, 4'b0000, 32'h00000000, rd);
    wb_access(0, 0, 20, 4'hF, 0, rd); check("R4", "no lanes selected", rd, 32'hFF22FF44);
    wb_access(0, 1, 20, 4'b1000, 32'hAB000000, rd);
    wb_access(0, 0, 20, 4'hF, 0, rd); check("R4", "top lane", rd, 32'hAB22FF44);
  endtask

  // usr_clk of the main instance is tied low, so every user access here relies on R10
  task automatic t_user_main;
    logic [31:0] rd;
    usr_main(1, 30, 4'hF, 32'hCAFEF00D, rd);
    wb_access(0, 0, 30, 4'hF, 0, rd); check("R7", "user write seen on bus (R10)", rd, 32'hCAFEF00D);
    usr_main(1, 30, 4'b0010, 32'h00005500, rd);
    wb_access(0, 0, 30, 4'hF, 0, rd); check("R6", "user lane 1 only", rd, 32'hCAFE550D);
    usr_main(0, 30, 4'h0, 0, rd);     check("R9", "write-only user read", rd, 32'h0);
    wb_access(0, 1, 31, 4'hF, 32'h12345678, rd);
    usr_main(0, 31, 4'h0, 0, rd);     check("R9", "write-only user read after bus write", rd, 32'h0);
  endtask

  task automatic t_alt;
    logic [31:0] rd;
    logic [15:0] pre, urd;
    wb_access(1, 1, 3, 4'b0001, 32'hABCD1234, rd);
    wb_access(1, 0, 3, 4'hF, 0, rd);      check("R4", "full word without byte select", rd, 32'h00001234);
    check("R1", "upper bus bits zero", {16'd0, rd[31:16]}, 32'h0);
    usr_alt(0, 3, 0, pre, urd);           check("R7", "bus write seen on user clock", {16'd0, urd}, 32'h1234);
    wb_access(1, 1, 2*64 + 9, 4'hF, 32'h0000BEEF, rd);
    usr_alt(0, 9, 0, pre, urd);           check("R2", "alt mirror copy 2", {16'd0, urd}, 32'hBEEF);
    usr_alt(0, 3, 0, pre, urd);
    check("R5", "old data before user edge", {16'd0, pre}, 32'hBEEF);
    check("R5", "new data after user edge", {16'd0, urd}, 32'h1234);
    usr_alt(1, 3, 16'hFFFF, pre, urd);
    usr_alt(0, 3, 0, pre, urd);           check("R8", "read-only user write ignored", {16'd0, urd}, 32'h1234);
    wb_access(1, 0, 64 + 3, 4'hF, 0, rd); check("R8", "bus sees word unchanged", rd, 32'h00001234);
  endtask

  initial begin
    repeat (4) @(posedge wb_clk);
    @(negedge wb_clk);
    wb_rst = 0;
    t_reset;
    t_basic;
    t_mirror;
    t_bus_lanes;
    t_user_main;
    t_alt;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge wb_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule